// File: doc/BRIEF.md
# PCI Target Termination Request Controller

This block sits on the local side of a PCI target interface. It decides when the bus interface should end a target transaction early. It also drives the local ready strobe for each data phase. Three checks feed that decision, and they run in parallel. A latency budget counts clocks in each data phase. A burst address tracker compares the next transfer address against the target's decode window. A byte-enable check flags I/O accesses that reach into bytes the target does not own within a shared DWORD.

The block drives three active-low requests: ready, disconnect and target-abort. An abort always wins over a disconnect. Once a request is raised it is held until the transaction completes. Completion means the acknowledge input and the transaction-active status input are both deasserted. On completion every request is released, so that a transaction starting back-to-back does not inherit a stale ready. When the local side stalls the last data phase of a write, the block saves that write word into a holding register. The word is kept there until the consumer takes it, even if a new transaction starts in the meantime.

Top module: `pci_tgt_term_ctrl`

## Requirements
- R1: After synchronous reset, `rdy_n`, `disc_n` and `abort_n` are 1 and `hold_vld` is 0.
- R2: A transaction starts with `txn_start` high for one cycle. If the first data phase does not complete (`phase_done`), `disc_n` stays 1 for the first 15 clocks after the start edge and is 0 on the 16th.
- R3: The latency limit for every data phase after the first is 8 clocks. Counting starts at the edge on which the previous phase completed. `disc_n` is 1 on clocks 1 to 7 and 0 on clock 8 if that phase has not completed.
- R4: The phase latency counter restarts at zero on each completed phase and saturates rather than wrapping. A disconnect request, once raised, stays raised until the transaction completes.
- R5: The transfer address loads from `txn_addr` at the start and advances by 4 on each completed phase. If a completed phase leaves the next address outside the window [WIN_LO, WIN_HI] (defaults 0x100 to 0x10F), `disc_n` goes to 0 in the next cycle.
- R6: For an I/O transaction (`txn_io` = 1), `be_n` bit i = 0 enables byte i. If any enabled byte lies outside OWN_BE (default 4'b0011, i.e. bytes 0 and 1 are owned), `abort_n` goes to 0 in the next cycle and `rdy_n` is forced to 1. Memory transactions never abort, and neither do I/O accesses confined to the owned bytes.
- R7: `abort_n` and `disc_n` are never 0 together. When both conditions hold, abort takes priority.
- R8: While a transaction is active, `rdy_n` is the registered inverse of `local_rdy`. In the cycle after `ack_n` = 1 and `txn_act` = 0 are sampled, all three requests are 1. They stay 1 while idle, whatever `local_rdy` is.
- R9: A write word `wr_data` is captured into `hold_data` and `hold_vld` is set when a write transaction's `last_phase` and `wr_vld` are high while `local_rdy` is 0. The word is kept across later transactions until `hold_take` clears `hold_vld`. Without the stall nothing is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_start | input | 1 | One-cycle pulse starting a target transaction |
| txn_addr | input | AW | Start address of the transaction |
| txn_io | input | 1 | Transaction is an I/O access |
| txn_write | input | 1 | Transaction is a write |
| ack_n | input | 1 | Acknowledge from the bus interface, active low |
| txn_act | input | 1 | Transaction-active status, high while in progress |
| phase_done | input | 1 | Current data phase completed this cycle |
| last_phase | input | 1 | Current data phase is the last one |
| local_rdy | input | 1 | Local data path can transfer this phase |
| be_n | input | BE_W | Byte enables, active low |
| wr_data | input | DW | Write data of the current phase |
| wr_vld | input | 1 | `wr_data` is valid |
| hold_take | input | 1 | Consumer takes the held word |
| rdy_n | output | 1 | Local ready, active low |
| disc_n | output | 1 | Disconnect request, active low |
| abort_n | output | 1 | Target-abort request, active low |
| hold_data | output | DW | Holding register contents |
| hold_vld | output | 1 | Holding register holds an untaken word |

## Verification
Assertions check some properties on every cycle:
- the two termination requests are mutually exclusive (R7);
- all requests are released after completion (R8);
- a byte-enable violation leads to an abort (R6);
- the latency counter saturates (R4);
- the address steps by 4 per completed phase (R5);
- the holding register captures on a stalled last write phase (R9).

Some behaviour only the directed scenarios can show. These are the exact clock on which the 16- and 8-clock budgets trip (R2, R3) and the exact phase at which the window boundary disconnects (R5). They also cover memory accesses and owned-byte accesses that must not abort (R6), and the held word surviving a following transaction (R9).

// File: rtl/pci_term_pkg.sv
package pci_term_pkg;
  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_ACTIVE = 1'b1
  } term_st_e;

  localparam int ADDR_STEP = 4;
endpackage

// File: rtl/pci_term_latency.sv
module pci_term_latency #(
  parameter int FIRST_LIM = 16,
  parameter int NEXT_LIM  = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic active,
  input  logic phase_done,
  output logic over
);
  localparam int CW = $clog2(FIRST_LIM + 1);
  localparam logic [CW-1:0] CMAX     = '1;
  localparam logic [CW-1:0] FIRST_TH = CW'(FIRST_LIM - 2);
  localparam logic [CW-1:0] NEXT_TH  = CW'(NEXT_LIM - 2);

  logic [CW-1:0] cnt;
  logic          first;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      first <= 1'b1;
    end else if (start) begin
      cnt   <= '0;
      first <= 1'b1;
    end else if (active) begin
      if (phase_done) begin
        cnt   <= '0;
        first <= 1'b0;
      end else if (cnt != CMAX) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_comb begin
    over = active && !phase_done && (cnt >= (first ? FIRST_TH : NEXT_TH));
  end

  // R4: counter holds at its ceiling instead of wrapping
  a_r4_lat_saturates: assert property (@(posedge clk) disable iff (rst)
    (cnt == CMAX && active && !phase_done && !start) |=> (cnt == CMAX));
endmodule

// File: rtl/pci_term_addr_window.sv
module pci_term_addr_window
  import pci_term_pkg::*;
#(
  parameter int            AW     = 32,
  parameter logic [AW-1:0] WIN_LO = AW'('h100),
  parameter logic [AW-1:0] WIN_HI = AW'('h10F)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic          step,
  output logic          out_of_win
);
  logic [AW-1:0] addr_q;
  logic [AW:0]   nxt;

  always_ff @(posedge clk) begin
    if (rst)        addr_q <= '0;
    else if (load)  addr_q <= load_addr;
    else if (step)  addr_q <= addr_q + AW'(ADDR_STEP);
  end

  always_comb begin
    nxt        = {1'b0, addr_q} + (AW+1)'(ADDR_STEP);
    out_of_win = step && ((nxt > {1'b0, WIN_HI}) || (nxt < {1'b0, WIN_LO}));
  end

  // R5: each completed phase advances the transfer address by one DWORD
  a_r5_addr_step: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> (addr_q == $past(addr_q) + AW'(ADDR_STEP)));
endmodule

// File: rtl/pci_term_be_check.sv
module pci_term_be_check #(
  parameter int              BE_W   = 4,
  parameter logic [BE_W-1:0] OWN_BE = 4'b0011
) (
  input  logic            is_io,
  input  logic [BE_W-1:0] be_n,
  output logic            viol
);
  always_comb begin
    viol = is_io && (|(~be_n & ~OWN_BE));
  end
endmodule

// File: rtl/pci_term_hold.sv
module pci_term_hold #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          capture,
  input  logic          take,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] hold_data,
  output logic          hold_vld
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_data <= '0;
      hold_vld  <= 1'b0;
    end else if (capture) begin
      hold_data <= din;
      hold_vld  <= 1'b1;
    end else if (take) begin
      hold_vld  <= 1'b0;
    end
  end

  // R9: a stalled last write phase lands in the holding register
  a_r9_hold_capture: assert property (@(posedge clk) disable iff (rst)
    capture |=> (hold_vld && hold_data == $past(din)));
endmodule

// File: rtl/pci_tgt_term_ctrl.sv
module pci_tgt_term_ctrl
  import pci_term_pkg::*;
#(
  parameter int              AW        = 32,
  parameter int              DW        = 32,
  parameter int              BE_W      = 4,
  parameter int              FIRST_LIM = 16,
  parameter int              NEXT_LIM  = 8,
  parameter logic [AW-1:0]   WIN_LO    = AW'('h100),
  parameter logic [AW-1:0]   WIN_HI    = AW'('h10F),
  parameter logic [BE_W-1:0] OWN_BE    = 4'b0011
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            txn_start,
  input  logic [AW-1:0]   txn_addr,
  input  logic            txn_io,
  input  logic            txn_write,
  input  logic            ack_n,
  input  logic            txn_act,
  input  logic            phase_done,
  input  logic            last_phase,
  input  logic            local_rdy,
  input  logic [BE_W-1:0] be_n,
  input  logic [DW-1:0]   wr_data,
  input  logic            wr_vld,
  input  logic            hold_take,
  output logic            rdy_n,
  output logic            disc_n,
  output logic            abort_n,
  output logic [DW-1:0]   hold_data,
  output logic            hold_vld
);
  term_st_e state;
  logic     io_q, wr_q;
  logic     active, start_go, done;
  logic     lat_over, win_out, be_viol, capture;
  logic     abort_req, disc_req;

  always_comb begin
    active   = (state == ST_ACTIVE);
    start_go = (state == ST_IDLE) && txn_start;
    done     = active && ack_n && !txn_act;
    capture  = active && wr_q && last_phase && wr_vld && !local_rdy;
  end

  pci_term_latency #(.FIRST_LIM(FIRST_LIM), .NEXT_LIM(NEXT_LIM)) u_lat (
    .clk(clk), .rst(rst), .start(start_go), .active(active),
    .phase_done(phase_done), .over(lat_over)
  );

  pci_term_addr_window #(.AW(AW), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_win (
    .clk(clk), .rst(rst), .load(start_go), .load_addr(txn_addr),
    .step(active && phase_done), .out_of_win(win_out)
  );

  pci_term_be_check #(.BE_W(BE_W), .OWN_BE(OWN_BE)) u_be (
    .is_io(active && io_q), .be_n(be_n), .viol(be_viol)
  );

  pci_term_hold #(.DW(DW)) u_hold (
    .clk(clk), .rst(rst), .capture(capture), .take(hold_take),
    .din(wr_data), .hold_data(hold_data), .hold_vld(hold_vld)
  );

  always_comb begin
    abort_req = !abort_n || be_viol;
    disc_req  = (!disc_n || lat_over || win_out) && !abort_req;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      io_q    <= 1'b0;
      wr_q    <= 1'b0;
      rdy_n   <= 1'b1;
      disc_n  <= 1'b1;
      abort_n <= 1'b1;
    end else if (start_go) begin
      state <= ST_ACTIVE;
      io_q  <= txn_io;
      wr_q  <= txn_write;
    end else if (active) begin
      if (done) begin
        state   <= ST_IDLE;
        rdy_n   <= 1'b1;
        disc_n  <= 1'b1;
        abort_n <= 1'b1;
      end else begin
        abort_n <= !abort_req;
        disc_n  <= !disc_req;
        rdy_n   <= !(local_rdy && !abort_req);
      end
    end
  end

  // R7: at most one termination request at a time
  a_r7_single_term: assert property (@(posedge clk) disable iff (rst)
    $onehot0({!abort_n, !disc_n}));

  // R8: completion releases every request on the next cycle
  a_r8_release_on_done: assert property (@(posedge clk) disable iff (rst)
    done |=> (rdy_n && disc_n && abort_n));

  // R6: a shared-DWORD byte-enable violation raises abort and drops ready
  a_r6_abort_on_be: assert property (@(posedge clk) disable iff (rst)
    (be_viol && !done) |=> (!abort_n && rdy_n));
endmodule

// File: tb/pci_tgt_term_ctrl_bench.sv
`timescale 1ns/1ps
module pci_tgt_term_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        txn_start, txn_io, txn_write, ack_n, txn_act;
  logic        phase_done, last_phase, local_rdy, wr_vld, hold_take;
  logic [31:0] txn_addr, wr_data;
  logic [3:0]  be_n;
  logic        rdy_n, disc_n, abort_n, hold_vld;
  logic [31:0] hold_data;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  pci_tgt_term_ctrl u_pci_tgt_term_ctrl (
    .clk(clk), .rst(rst), .txn_start(txn_start), .txn_addr(txn_addr),
    .txn_io(txn_io), .txn_write(txn_write), .ack_n(ack_n), .txn_act(txn_act),
    .phase_done(phase_done), .last_phase(last_phase), .local_rdy(local_rdy),
    .be_n(be_n), .wr_data(wr_data), .wr_vld(wr_vld), .hold_take(hold_take),
    .rdy_n(rdy_n), .disc_n(disc_n), .abort_n(abort_n),
    .hold_data(hold_data), .hold_vld(hold_vld)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic start_txn(input logic [31:0] a, input logic io, input logic wr);
    txn_start = 1'b1; txn_addr = a; txn_io = io; txn_write = wr;
    tick();
    txn_start = 1'b0;
  endtask

  task automatic finish_txn();
    phase_done = 1'b0; last_phase = 1'b0; wr_vld = 1'b0; local_rdy = 1'b0;
    ack_n = 1'b1; txn_act = 1'b0;
    tick();
    chk(rdy_n && disc_n && abort_n, "R8 release", {rdy_n, disc_n, abort_n}, 3'b111);
    ack_n = 1'b0; txn_act = 1'b1; be_n = 4'hF;
    tick();
  endtask

  task automatic t_reset();
    chk(rdy_n && disc_n && abort_n, "R1 requests", {rdy_n, disc_n, abort_n}, 3'b111);
    chk(!hold_vld, "R1 hold_vld", hold_vld, 0);
  endtask

  task automatic t_first_phase();
    start_txn(32'h100, 1'b0, 1'b0);
    for (int i = 1; i <= 15; i++) begin
      chk(disc_n, "R2 before limit", disc_n, 1);
      tick();
    end
    chk(!disc_n, "R2 16th clock", disc_n, 0);
    repeat (30) tick();
    chk(!disc_n, "R4 held and no wrap", disc_n, 0);
    finish_txn();
  endtask

  task automatic t_next_phase();
    start_txn(32'h100, 1'b0, 1'b0);
    phase_done = 1'b1;
    tick();
    phase_done = 1'b0;
    for (int i = 1; i <= 7; i++) begin
      chk(disc_n, "R3 before limit", disc_n, 1);
      tick();
    end
    chk(!disc_n, "R3 8th clock", disc_n, 0);
    finish_txn();
  endtask

  task automatic t_window();
    start_txn(32'h104, 1'b0, 1'b0);
    phase_done = 1'b1;
    tick();
    chk(disc_n, "R5 0x108 in window", disc_n, 1);
    tick();
    chk(disc_n, "R5 0x10C in window", disc_n, 1);
    tick();
    phase_done = 1'b0;
    chk(!disc_n, "R5 0x110 beyond window", disc_n, 0);
    tick();
    chk(!disc_n, "R4 disconnect held", disc_n, 0);
    finish_txn();
  endtask

  task automatic t_abort();
    be_n = 4'b1011;
    local_rdy = 1'b1;
    start_txn(32'h100, 1'b1, 1'b0);
    tick();
    chk(!abort_n, "R6 abort on foreign byte", abort_n, 0);
    chk(rdy_n, "R6 ready withheld", rdy_n, 1);
    repeat (16) tick();
    chk(!abort_n && disc_n, "R7 abort wins", {abort_n, disc_n}, 2'b01);
    finish_txn();
    be_n = 4'b1011;
    start_txn(32'h100, 1'b0, 1'b0);
    repeat (3) tick();
    chk(abort_n, "R6 memory never aborts", abort_n, 1);
    finish_txn();
    be_n = 4'b1100;
    start_txn(32'h100, 1'b1, 1'b0);
    repeat (3) tick();
    chk(abort_n, "R6 owned bytes no abort", abort_n, 1);
    finish_txn();
  endtask

  task automatic t_ready();
    start_txn(32'h100, 1'b0, 1'b0);
    local_rdy = 1'b1;
    tick();
    chk(!rdy_n, "R8 ready follows local", rdy_n, 0);
    ack_n = 1'b1; txn_act = 1'b0;
    tick();
    chk(rdy_n, "R8 ready dropped on done", rdy_n, 1);
    ack_n = 1'b0; txn_act = 1'b1;
    tick();
    chk(rdy_n, "R8 idle ready stays high", rdy_n, 1);
    local_rdy = 1'b0;
    tick();
  endtask

  task automatic t_hold();
    start_txn(32'h100, 1'b0, 1'b1);
    last_phase = 1'b1; wr_vld = 1'b1; wr_data = 32'hA5A5_0001; local_rdy = 1'b0;
    tick();
    chk(hold_vld && hold_data == 32'hA5A5_0001, "R9 capture",
        hold_data, 32'hA5A5_0001);
    finish_txn();
    start_txn(32'h100, 1'b0, 1'b1);
    last_phase = 1'b1; wr_vld = 1'b1; wr_data = 32'h1234_5678; local_rdy = 1'b1;
    tick();
    chk(hold_vld && hold_data == 32'hA5A5_0001, "R9 kept across txn",
        hold_data, 32'hA5A5_0001);
    finish_txn();
    hold_take = 1'b1;
    tick();
    hold_take = 1'b0;
    chk(!hold_vld, "R9 take clears", hold_vld, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1; txn_start = 1'b0; txn_addr = '0; txn_io = 1'b0; txn_write = 1'b0;
    ack_n = 1'b0; txn_act = 1'b1; phase_done = 1'b0; last_phase = 1'b0;
    local_rdy = 1'b0; be_n = 4'hF; wr_data = '0; wr_vld = 1'b0; hold_take = 1'b0;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    t_reset();
    t_first_phase();
    t_next_phase();
    t_window();
    t_abort();
    t_ready();
    t_hold();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule